// File: doc/BRIEF.md
# Nested Trap State Stack Controller

This block keeps the processor state that must survive a trap. It holds one slot for each trap level. When a trap is taken, the current condition codes, address-space identifier, processor-state word and window pointer are packed into one state word. That word, the interrupted PC, the next PC and the trap type go into the slot for the current level. The block then forms the trap vector from the vector base, the trap type and the level. It moves the level up, sets the privileged processor state, and moves the window pointer when the trap is one of the window traps.

A trap return takes the topmost slot back out, in one of two forms. Retry re-executes the trapped instruction. Done resumes after the trapped instruction. Either form restores the four architectural fields and lowers the level. All results are registered and appear one clock after the request. Entering a trap when the level is already at its maximum raises a sticky error-state flag instead of trapping. A return at level zero raises a one-cycle illegal-operation flag.

Top module: `trap_state_ctl`

## Requirements
- R1: While reset is held (synchronous, active low), and in the first cycle after it, trap_level, pc_out, npc_out, vector_out, pstate_out, cwp_out, ccr_out, asi_out, top_tt, error_state and illegal_ret are all zero.
- R2: An accepted trap saves a state word in the slot indexed by the current level. The word's fields are: window pointer in bits [7:0]; processor state ANDed with 0xF3F in bits [19:8]; ASI in [31:24]; condition codes in [39:32]. A later return restores ccr_out, asi_out, cwp_out and pstate_out from that word, so processor-state bits 6 and 7 come back as zero.
- R3: After an accepted trap, pstate_out is 0x015 (bit 0 alternate globals, bit 2 privileged, bit 4 FP enable). When the level before the trap was the maximum minus one, bit 5 (RED) is also set, giving 0x035.
- R4: The vector is built as follows: the upper base bits occupy [63:15], bit 14 is 1 when the level before the trap is greater than 1, the 9-bit trap type occupies [13:5], and bits [4:0] are zero. After an accepted trap, vector_out and pc_out equal this value, npc_out equals it plus 4, and ccr_out and asi_out take the current inputs.
- R5: The window pointer changes according to the trap type:
  - type 0x024: pointer minus 1;
  - type bits [8:6] = 3'b010: pointer minus can-save minus 2;
  - type bits [8:6] = 3'b011: pointer plus 1;
  - any other type: unchanged.
  All window arithmetic is modulo the window count.
- R6: An accepted trap raises trap_level by one, and trap_level never exceeds the maximum. A trap request at the maximum level sets error_state and changes no other output. error_state stays set until reset, and while it is set, trap requests change nothing.
- R7: Retry at a nonzero level loads pc_out with the saved PC and npc_out with the saved next PC, and lowers trap_level by one.
- R8: Done at a nonzero level loads pc_out with the saved next PC and npc_out with the saved next PC plus 4, and lowers trap_level by one.
- R9: A return at level zero pulses illegal_ret for exactly one cycle and leaves every other output unchanged.
- R10: When a trap request and a return request arrive in the same cycle, the trap request is handled and the return is ignored.
- R11: Nested traps return in last-in-first-out order. top_tt shows the trap type saved for the topmost occupied level, and is zero at level 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_req | input | 1 | Take a trap this cycle |
| trap_type | input | TT_W | Trap type of the request |
| cur_ccr | input | 8 | Current condition codes |
| cur_asi | input | 8 | Current address-space identifier |
| cur_pstate | input | 12 | Current processor-state word |
| cur_cwp | input | log2(NWIN) | Current window pointer |
| cur_cansave | input | log2(NWIN) | Current can-save count |
| cur_pc | input | ADDR_W | PC of the trapped instruction |
| cur_npc | input | ADDR_W | Next PC at the trap |
| vec_base_hi | input | ADDR_W-TT_W-6 | Vector base bits above bit 14 |
| ret_req | input | 1 | Return from the topmost trap |
| ret_retry | input | 1 | 1 selects retry, 0 selects done |
| pc_out | output | ADDR_W | New PC |
| npc_out | output | ADDR_W | New next PC |
| vector_out | output | ADDR_W | Last trap vector formed |
| trap_level | output | log2(MAX_TL+1) | Current trap level |
| pstate_out | output | 12 | Current processor-state word |
| cwp_out | output | log2(NWIN) | Current window pointer |
| ccr_out | output | 8 | Current condition codes |
| asi_out | output | 8 | Current address-space identifier |
| top_tt | output | TT_W | Trap type saved for the topmost level |
| error_state | output | 1 | Sticky: a trap was requested at the maximum level |
| illegal_ret | output | 1 | One-cycle pulse: return requested at level 0 |

## Verification
A bad level counter shows at the ports within one cycle, because trap_level is an output. It then shows again at the next return, when the wrong slot comes back. A slot saved with a mispacked field stays hidden until the return that pops it, possibly several levels later. For that reason the bench nests to the maximum depth and unwinds fully, with a different value in every field at each level. Every output is compared with a behavioural model on every clock, so a mistake in the window arithmetic or the vector bits shows up in the cycle right after the trap.

// File: rtl/tsc_pkg.sv
// Shared types and constants for the trap state stack controller.
// Assumes an 8-bit condition-code field, an 8-bit ASI and a 12-bit
// processor-state word.
package tsc_pkg;
    localparam int CCR_W = 8;
    localparam int ASI_W = 8;
    localparam int PST_W = 12;

    // Processor-state bits that survive in the saved word
    localparam logic [PST_W-1:0] PST_KEEP = 12'hF3F;
    localparam int PST_AG   = 0;
    localparam int PST_PRIV = 2;
    localparam int PST_PEF  = 4;
    localparam int PST_RED  = 5;

    // Bit position of the trap type inside the vector
    localparam int VEC_TT_LSB = 5;

    // Saved state word; field positions matter to software reading it back
    typedef struct packed {
        logic [CCR_W-1:0] ccr;   // [39:32]
        logic [ASI_W-1:0] asi;   // [31:24]
        logic [3:0]       rsvd;  // [23:20]
        logic [PST_W-1:0] pst;   // [19:8]
        logic [7:0]       win;   // [7:0]
    } state_word_t;

    typedef enum logic [1:0] {
        WIN_KEEP,
        WIN_CLEAN,
        WIN_SPILL,
        WIN_FILL
    } win_op_e;

    // Processor state forced on trap entry, optionally with RED
    function automatic logic [PST_W-1:0] entry_pstate(input logic red);
        logic [PST_W-1:0] p;
        p = '0;
        p[PST_AG]   = 1'b1;
        p[PST_PRIV] = 1'b1;
        p[PST_PEF]  = 1'b1;
        p[PST_RED]  = red;
        return p;
    endfunction
endpackage

// File: rtl/tsc_win_adjust.sv
// Window pointer adjustment on trap entry.
// Classifies the trap type as a clean-window, spill or fill trap and
// computes the new window pointer.
// Assumes NWIN is a power of two, so wrap-around of a log2(NWIN)-bit
// value gives the required modulo arithmetic.
module tsc_win_adjust
    import tsc_pkg::*;
#(
    parameter int TT_W = 9,
    parameter int NWIN = 8
) (
    input  logic [TT_W-1:0]          tt,
    input  logic [$clog2(NWIN)-1:0]  cwp,
    input  logic [$clog2(NWIN)-1:0]  cansave,
    output logic [$clog2(NWIN)-1:0]  cwp_next,
    output win_op_e                  op
);
    localparam int CW = $clog2(NWIN);
    localparam logic [TT_W-1:0] CLEAN_TT  = TT_W'(9'h024);
    localparam logic [2:0]      SPILL_GRP = 3'b010;
    localparam logic [2:0]      FILL_GRP  = 3'b011;

    // Decode the trap type into a window operation
    always_comb begin
        if (tt == CLEAN_TT)                 op = WIN_CLEAN;
        else if (tt[TT_W-1 -: 3] == SPILL_GRP) op = WIN_SPILL;
        else if (tt[TT_W-1 -: 3] == FILL_GRP)  op = WIN_FILL;
        else                                op = WIN_KEEP;
    end

    // Apply the window arithmetic, wrapping modulo NWIN
    always_comb begin
        unique case (op)
            WIN_CLEAN: cwp_next = cwp - CW'(1);
            WIN_SPILL: cwp_next = cwp - cansave - CW'(2);
            WIN_FILL:  cwp_next = cwp + CW'(1);
            default:   cwp_next = cwp;
        endcase
    end
endmodule

// File: rtl/tsc_vector.sv
// Trap vector former.
// Combines the upper base bits, a level flag and the trap type.
// Assumes the trap type sits at bit 5 and the level flag sits just
// above the trap type field.
module tsc_vector
    import tsc_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int TT_W   = 9,
    parameter int TL_W   = 3
) (
    input  logic [ADDR_W-TT_W-VEC_TT_LSB-2:0] base_hi,
    input  logic [TT_W-1:0]                   tt,
    input  logic [TL_W-1:0]                   tl,
    output logic [ADDR_W-1:0]                 vec,
    output logic [ADDR_W-1:0]                 vec_plus4
);
    logic nested;

    // Level flag: set for traps taken above level 1
    assign nested = (tl > TL_W'(1));

    // Assemble the vector and its successor
    assign vec       = {base_hi, nested, tt, {VEC_TT_LSB{1'b0}}};
    assign vec_plus4 = vec + ADDR_W'(4);
endmodule

// File: rtl/tsc_stack.sv
// Per-level save storage.
// Holds DEPTH slots of {state word, PC, next PC, trap type}, with one
// write port and one combinational read port.
// Assumes the index is at least as wide as needed for DEPTH-1. An
// out-of-range read index returns zeros.
module tsc_stack
    import tsc_pkg::*;
#(
    parameter int DEPTH  = 5,
    parameter int ADDR_W = 64,
    parameter int TT_W   = 9,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  state_word_t       w_word,
    input  logic [ADDR_W-1:0] w_pc,
    input  logic [ADDR_W-1:0] w_npc,
    input  logic [TT_W-1:0]   w_tt,
    input  logic [IDX_W-1:0]  ridx,
    output state_word_t       r_word,
    output logic [ADDR_W-1:0] r_pc,
    output logic [ADDR_W-1:0] r_npc,
    output logic [TT_W-1:0]   r_tt
);
    state_word_t       word_q [DEPTH];
    logic [ADDR_W-1:0] pc_q   [DEPTH];
    logic [ADDR_W-1:0] npc_q  [DEPTH];
    logic [TT_W-1:0]   tt_q   [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        // Capture one slot when it is the write target
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q[g] <= '0;
                pc_q[g]   <= '0;
                npc_q[g]  <= '0;
                tt_q[g]   <= '0;
            end else if (we && (widx == IDX_W'(g))) begin
                word_q[g] <= w_word;
                pc_q[g]   <= w_pc;
                npc_q[g]  <= w_npc;
                tt_q[g]   <= w_tt;
            end
        end
    end

    // Select the slot named by the read index
    always_comb begin
        r_word = '0;
        r_pc   = '0;
        r_npc  = '0;
        r_tt   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (ridx == IDX_W'(i)) begin
                r_word = word_q[i];
                r_pc   = pc_q[i];
                r_npc  = npc_q[i];
                r_tt   = tt_q[i];
            end
        end
    end
endmodule

// File: rtl/trap_state_ctl.sv
// Nested trap state stack controller (top).
// On an accepted trap it saves the packed state, PC, next PC and type in
// the slot for the current level, then jumps to the vector and raises the
// level. On a return it restores from the topmost slot, with retry or done
// semantics. A trap request wins over a return in the same cycle.
// All outputs are registered, one cycle after the request.
module trap_state_ctl
    import tsc_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int TT_W   = 9,
    parameter int MAX_TL = 5,
    parameter int NWIN   = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           trap_req,
    input  logic [TT_W-1:0]                trap_type,
    input  logic [CCR_W-1:0]               cur_ccr,
    input  logic [ASI_W-1:0]               cur_asi,
    input  logic [PST_W-1:0]               cur_pstate,
    input  logic [$clog2(NWIN)-1:0]        cur_cwp,
    input  logic [$clog2(NWIN)-1:0]        cur_cansave,
    input  logic [ADDR_W-1:0]              cur_pc,
    input  logic [ADDR_W-1:0]              cur_npc,
    input  logic [ADDR_W-TT_W-7:0]         vec_base_hi,
    input  logic                           ret_req,
    input  logic                           ret_retry,
    output logic [ADDR_W-1:0]              pc_out,
    output logic [ADDR_W-1:0]              npc_out,
    output logic [ADDR_W-1:0]              vector_out,
    output logic [$clog2(MAX_TL+1)-1:0]    trap_level,
    output logic [PST_W-1:0]               pstate_out,
    output logic [$clog2(NWIN)-1:0]        cwp_out,
    output logic [CCR_W-1:0]               ccr_out,
    output logic [ASI_W-1:0]               asi_out,
    output logic [TT_W-1:0]                top_tt,
    output logic                           error_state,
    output logic                           illegal_ret
);
    localparam int TL_W = $clog2(MAX_TL + 1);
    localparam int CW   = $clog2(NWIN);
    localparam logic [TL_W-1:0] TL_MAX  = TL_W'(MAX_TL);
    localparam logic [TL_W-1:0] TL_NEAR = TL_W'(MAX_TL - 1);

    // Architectural state registers
    logic [TL_W-1:0]   tl_q;
    logic              err_q, ill_q;
    logic [ADDR_W-1:0] pc_q, npc_q, vec_q;
    logic [PST_W-1:0]  pst_q;
    logic [CW-1:0]     cwp_q;
    logic [CCR_W-1:0]  ccr_q;
    logic [ASI_W-1:0]  asi_q;

    // Request qualification
    logic tl_at_max, take_trap, trap_blocked, do_ret, ret_ok;
    assign tl_at_max    = (tl_q == TL_MAX);
    assign take_trap    = trap_req && !err_q && !tl_at_max;
    assign trap_blocked = trap_req && !err_q && tl_at_max;
    assign do_ret       = ret_req && !trap_req;
    assign ret_ok       = do_ret && (tl_q != '0);

    // Pack the current architectural fields into a state word
    state_word_t save_word;
    always_comb begin
        save_word      = '0;
        save_word.ccr  = cur_ccr;
        save_word.asi  = cur_asi;
        save_word.pst  = cur_pstate & PST_KEEP;
        save_word.win  = 8'(cur_cwp);
    end

    // Window adjustment
    logic [CW-1:0] cwp_adj;
    win_op_e       win_op;
    tsc_win_adjust #(.TT_W(TT_W), .NWIN(NWIN)) u_win (
        .tt       (trap_type),
        .cwp      (cur_cwp),
        .cansave  (cur_cansave),
        .cwp_next (cwp_adj),
        .op       (win_op)
    );

    // Vector formation
    logic [ADDR_W-1:0] vec, vec_plus4;
    tsc_vector #(.ADDR_W(ADDR_W), .TT_W(TT_W), .TL_W(TL_W)) u_vec (
        .base_hi   (vec_base_hi),
        .tt        (trap_type),
        .tl        (tl_q),
        .vec       (vec),
        .vec_plus4 (vec_plus4)
    );

    // Save storage; the topmost occupied slot is tl-1
    state_word_t       rd_word;
    logic [ADDR_W-1:0] rd_pc, rd_npc;
    logic [TT_W-1:0]   rd_tt;
    logic [TL_W-1:0]   rd_idx;
    assign rd_idx = tl_q - TL_W'(1);

    tsc_stack #(.DEPTH(MAX_TL), .ADDR_W(ADDR_W), .TT_W(TT_W), .IDX_W(TL_W)) u_stack (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (take_trap),
        .widx   (tl_q),
        .w_word (save_word),
        .w_pc   (cur_pc),
        .w_npc  (cur_npc),
        .w_tt   (trap_type),
        .ridx   (rd_idx),
        .r_word (rd_word),
        .r_pc   (rd_pc),
        .r_npc  (rd_npc),
        .r_tt   (rd_tt)
    );

    // Sequence trap entry, error entry and trap return
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tl_q  <= '0;
            err_q <= 1'b0;
            ill_q <= 1'b0;
            pc_q  <= '0;
            npc_q <= '0;
            vec_q <= '0;
            pst_q <= '0;
            cwp_q <= '0;
            ccr_q <= '0;
            asi_q <= '0;
        end else begin
            ill_q <= 1'b0;
            if (take_trap) begin
                tl_q  <= tl_q + TL_W'(1);
                pc_q  <= vec;
                npc_q <= vec_plus4;
                vec_q <= vec;
                pst_q <= entry_pstate(tl_q == TL_NEAR);
                cwp_q <= cwp_adj;
                ccr_q <= cur_ccr;
                asi_q <= cur_asi;
            end else if (trap_blocked) begin
                err_q <= 1'b1;
            end else if (do_ret) begin
                if (ret_ok) begin
                    tl_q  <= tl_q - TL_W'(1);
                    pc_q  <= ret_retry ? rd_pc  : rd_npc;
                    npc_q <= ret_retry ? rd_npc : rd_npc + ADDR_W'(4);
                    pst_q <= rd_word.pst;
                    cwp_q <= rd_word.win[CW-1:0];
                    ccr_q <= rd_word.ccr;
                    asi_q <= rd_word.asi;
                end else begin
                    ill_q <= 1'b1;
                end
            end
        end
    end

    assign pc_out      = pc_q;
    assign npc_out     = npc_q;
    assign vector_out  = vec_q;
    assign trap_level  = tl_q;
    assign pstate_out  = pst_q;
    assign cwp_out     = cwp_q;
    assign ccr_out     = ccr_q;
    assign asi_out     = asi_q;
    assign error_state = err_q;
    assign illegal_ret = ill_q;
    assign top_tt      = (tl_q == '0) ? '0 : rd_tt;

    // ---------------- assertions ----------------
    assert_tl_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tl_q <= TL_MAX);

    assert_tl_inc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        take_trap |=> tl_q == TL_W'($past(tl_q) + TL_W'(1)));

    assert_err_on_max_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && !err_q && tl_q == TL_MAX) |=> (err_q && $stable(tl_q) && $stable(pc_q)));

    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);

    assert_entry_pst_R3: assert property (@(posedge clk) disable iff (!rst_n)
        take_trap |=> (pst_q[PST_PRIV] && pst_q[PST_PEF] && pst_q[PST_AG]));

    assert_entry_npc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take_trap |=> (npc_q == pc_q + ADDR_W'(4)) && (pc_q == vec_q));

    assert_ret_dec_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ret_ok |=> tl_q == TL_W'($past(tl_q) - TL_W'(1)));

    assert_ret_illegal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_req && !trap_req && tl_q == '0) |=> (ill_q && tl_q == '0 && $stable(pc_q)));

    assert_trap_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && ret_req) |=> !ill_q);
endmodule

// File: tb/tb_trap_state_ctl.sv
`timescale 1ns/1ps
module tb_trap_state_ctl;
    localparam int MAXL = 5;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n, trap_req, ret_req, ret_retry;
    logic [8:0]  trap_type;
    logic [7:0]  cur_ccr, cur_asi;
    logic [11:0] cur_pstate;
    logic [2:0]  cur_cwp, cur_cansave;
    logic [63:0] cur_pc, cur_npc;
    logic [48:0] vec_base_hi;
    logic [63:0] pc_out, npc_out, vector_out;
    logic [2:0]  trap_level;
    logic [11:0] pstate_out;
    logic [2:0]  cwp_out;
    logic [7:0]  ccr_out, asi_out;
    logic [8:0]  top_tt;
    logic        error_state, illegal_ret;

    trap_state_ctl dut (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_type(trap_type),
        .cur_ccr(cur_ccr), .cur_asi(cur_asi), .cur_pstate(cur_pstate),
        .cur_cwp(cur_cwp), .cur_cansave(cur_cansave), .cur_pc(cur_pc),
        .cur_npc(cur_npc), .vec_base_hi(vec_base_hi), .ret_req(ret_req),
        .ret_retry(ret_retry), .pc_out(pc_out), .npc_out(npc_out),
        .vector_out(vector_out), .trap_level(trap_level), .pstate_out(pstate_out),
        .cwp_out(cwp_out), .ccr_out(ccr_out), .asi_out(asi_out), .top_tt(top_tt),
        .error_state(error_state), .illegal_ret(illegal_ret)
    );

    // Behavioural reference model state
    int          e_tl;
    logic        e_err, e_ill;
    logic [63:0] e_pc, e_npc, e_vec;
    logic [11:0] e_pst;
    logic [2:0]  e_cwp;
    logic [7:0]  e_ccr, e_asi;
    logic [63:0] s_pc [MAXL];
    logic [63:0] s_npc[MAXL];
    logic [8:0]  s_tt [MAXL];
    logic [39:0] s_word[MAXL];

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    task automatic model_reset();
        e_tl = 0; e_err = 0; e_ill = 0;
        e_pc = '0; e_npc = '0; e_vec = '0; e_pst = '0; e_cwp = '0; e_ccr = '0; e_asi = '0;
        for (int i = 0; i < MAXL; i++) begin
            s_pc[i] = '0; s_npc[i] = '0; s_tt[i] = '0; s_word[i] = '0;
        end
    endtask

    task automatic model_update();
        logic [63:0] v;
        int w;
        if (!rst_n) begin
            model_reset();
            return;
        end
        e_ill = 0;
        if (trap_req) begin
            if (!e_err) begin
                if (e_tl == MAXL) begin
                    e_err = 1;
                end else begin
                    v = {vec_base_hi, (e_tl > 1) ? 1'b1 : 1'b0, trap_type, 5'b0};
                    s_pc[e_tl]   = cur_pc;
                    s_npc[e_tl]  = cur_npc;
                    s_tt[e_tl]   = trap_type;
                    s_word[e_tl] = {cur_ccr, cur_asi, 4'b0, cur_pstate & 12'hF3F, 5'b0, cur_cwp};
                    w = int'(cur_cwp);
                    if (trap_type == 9'h024)         w = w - 1;
                    else if (trap_type[8:6] == 3'b010) w = w - int'(cur_cansave) - 2;
                    else if (trap_type[8:6] == 3'b011) w = w + 1;
                    e_cwp = 3'(w & 7);
                    e_pst = (e_tl == MAXL - 1) ? 12'h035 : 12'h015;
                    e_pc = v; e_npc = v + 64'd4; e_vec = v;
                    e_ccr = cur_ccr; e_asi = cur_asi;
                    e_tl = e_tl + 1;
                end
            end
        end else if (ret_req) begin
            if (e_tl == 0) begin
                e_ill = 1;
            end else begin
                e_tl = e_tl - 1;
                e_pc  = ret_retry ? s_pc[e_tl]  : s_npc[e_tl];
                e_npc = ret_retry ? s_npc[e_tl] : s_npc[e_tl] + 64'd4;
                e_ccr = s_word[e_tl][39:32];
                e_asi = s_word[e_tl][31:24];
                e_pst = s_word[e_tl][19:8];
                e_cwp = s_word[e_tl][2:0];
            end
        end
    endtask

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "pc", pc_out, e_pc);
        chk(tag, "npc", npc_out, e_npc);
        chk(tag, "vector", vector_out, e_vec);
        chk(tag, "level", 64'(trap_level), 64'(e_tl));
        chk(tag, "pstate", 64'(pstate_out), 64'(e_pst));
        chk(tag, "cwp", 64'(cwp_out), 64'(e_cwp));
        chk(tag, "ccr", 64'(ccr_out), 64'(e_ccr));
        chk(tag, "asi", 64'(asi_out), 64'(e_asi));
        chk(tag, "top_tt", 64'(top_tt), (e_tl == 0) ? 64'd0 : 64'(s_tt[e_tl-1]));
        chk(tag, "error", 64'(error_state), 64'(e_err));
        chk(tag, "illegal", 64'(illegal_ret), 64'(e_ill));
    endtask

    // One clock: model follows the edge, outputs compared at the falling edge
    task automatic cycle(input string tag);
        @(posedge clk);
        model_update();
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic idle();
        trap_req = 0; ret_req = 0; ret_retry = 0;
    endtask

    task automatic set_trap(input logic [8:0] tt, input logic [2:0] cwp, input logic [2:0] cs,
                            input logic [7:0] ccr, input logic [7:0] asi, input logic [11:0] pst,
                            input logic [63:0] pc);
        trap_req = 1; trap_type = tt; cur_cwp = cwp; cur_cansave = cs;
        cur_ccr = ccr; cur_asi = asi; cur_pstate = pst; cur_pc = pc; cur_npc = pc + 64'd4;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        model_reset();
        rst_n = 0; idle();
        trap_type = '0; cur_ccr = '0; cur_asi = '0; cur_pstate = '0; cur_cwp = '0;
        cur_cansave = '0; cur_pc = '0; cur_npc = '0; vec_base_hi = 49'h1_2345_6789_ABCD;
        cycle("R1"); cycle("R1");
        rst_n = 1;
        cycle("R1");

        // Level 0 -> 1, plain type, pstate bits 6/7 set to show masking (R2, R4)
        set_trap(9'h041, 3'd3, 3'd2, 8'hA5, 8'h80, 12'hFFF, 64'h1000);
        cycle("R4");
        // Level 1 -> 2, clean window with wrap; return asserted too (R5, R10)
        set_trap(9'h024, 3'd0, 3'd1, 8'h11, 8'h82, 12'h0C3, 64'h2000);
        ret_req = 1; ret_retry = 1;
        cycle("R10");
        ret_req = 0;
        // Level 2 -> 3, spill; nested flag now set (R5, R4)
        set_trap(9'h085, 3'd1, 3'd6, 8'h22, 8'h88, 12'h815, 64'h3000);
        cycle("R5");
        // Level 3 -> 4, fill with wrap (R5)
        set_trap(9'h0C3, 3'd7, 3'd0, 8'h33, 8'h04, 12'h400, 64'h4000);
        cycle("R5");
        // Level 4 -> 5, RED state entry (R3)
        vec_base_hi = 49'h0_0000_0000_0F0F;
        set_trap(9'h100, 3'd5, 3'd3, 8'h44, 8'h10, 12'h200, 64'h5000);
        cycle("R3");
        // At maximum: error, return ignored (R6, R10)
        set_trap(9'h011, 3'd2, 3'd2, 8'h55, 8'h15, 12'h001, 64'h6000);
        ret_req = 1;
        cycle("R6");
        // Sticky error blocks traps (R6)
        ret_req = 0;
        set_trap(9'h012, 3'd4, 3'd1, 8'h66, 8'h19, 12'h002, 64'h7000);
        cycle("R6");
        idle(); cycle("R6");
        // Unwind in LIFO order, alternating done and retry (R7, R8, R11)
        for (int i = 0; i < MAXL; i++) begin
            ret_req = 1; ret_retry = i[0];
            cycle(i[0] ? "R7" : "R8");
            idle(); cycle("R11");
        end
        // Return at level 0 (R9)
        ret_req = 1; ret_retry = 0;
        cycle("R9");
        idle(); cycle("R9");
        // Reset clears error (R1)
        rst_n = 0; cycle("R1");
        rst_n = 1; cycle("R1");
        // Varied single-level round trips (R2, R4, R5, R7, R8)
        for (int k = 0; k < 24; k++) begin
            vec_base_hi = 49'(k * 64'h9E37_79B9);
            set_trap(9'(k * 37 + 5), 3'(k), 3'(k * 3), 8'(k * 29), 8'(k * 53), 12'(k * 411), 64'(k * 64'h1_0000_0040));
            cycle("R2");
            set_trap(9'(k * 11 + 128), 3'(k + 2), 3'(k), 8'(~k), 8'(k), 12'(k * 97), 64'(k * 64'h88));
            cycle("R5");
            idle(); ret_req = 1; ret_retry = k[0];
            cycle(k[0] ? "R7" : "R8");
            ret_retry = ~k[0];
            cycle("R2");
            idle(); cycle("R11");
        end
        summary();
    end
endmodule